// File: doc/BRIEF.md
# Partitionable Subword SIMD Adder

This block is a registered adder whose 36-bit datapath can be split into independent narrower lanes. A two-bit lane-mode input selects one of three shapes: a single 36-bit add, two 18-bit adds, or four 9-bit adds. Every lane applies the same addition to its own slice of the two operands, and all lanes run in lockstep. A carry that leaves the top bit of a lane is reported on that lane's carry flag. It is never passed into the lowest bit of the next lane.

The datapath is built from equal-width segment adders chained by carry. The mode decides at which segment joins the chain is cut. The sum and the per-lane carry flags are captured in a register when the input strobe is high, and a result strobe follows one clock later. Operands that arrive with the input strobe low leave the registered outputs unchanged.

Top module: `simd_add_top`

## Requirements
- R1: With mode 2'b00 the block produces the 36-bit sum of op_a and op_b modulo 2^36, and lane_carry[0] holds the carry out of bit 35.
- R2: With mode 2'b01 bits [17:0] and bits [35:18] are added as two separate 18-bit lanes. lane_carry[0] is the carry out of the low lane and lane_carry[1] is the carry out of the high lane. No carry passes from bit 17 into bit 18.
- R3: With mode 2'b10 lane k (k = 0..3) covers bits [9k+8:9k] and is added on its own, with lane_carry[k] as its carry out. No carry crosses bit 8/9, 17/18 or 26/27.
- R4: Mode 2'b11 gives exactly the same sum and flags as mode 2'b00.
- R5: Carry flags of lanes that the selected mode does not use read as zero: bits [3:1] in one-lane mode and bits [3:2] in two-lane mode.
- R6: out_valid equals the in_valid value sampled at the previous rising clock edge.
- R7: While in_valid is low, sum and lane_carry keep their last registered values, whatever op_a, op_b and mode do.
- R8: While rst_n is low, out_valid, sum and lane_carry are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | Lane shape: 00 one lane, 01 two lanes, 10 four lanes, 11 same as 00 |
| op_a | input | 36 | First operand |
| op_b | input | 36 | Second operand |
| out_valid | output | 1 | Registered result is new this cycle |
| sum | output | 36 | Registered lane-wise sum |
| lane_carry | output | 4 | Registered carry out per lane, lane 0 in bit 0 |

## Verification
The bench targets operands that put a carry exactly on each possible lane boundary: all-ones added to a one in every 9-bit slice, and all-ones plus all-ones. A design that cuts the chain in the wrong place shows a stray 1 at bit 9, 18 or 27, or a missing carry flag. The reserved mode is driven with the same operands as the single-lane mode, so a decoder that treats 2'b11 as four lanes gives a different sum. Flags of unused lanes are checked after inputs that would set them in four-lane mode. The bench also holds in_valid low while the operands change, which catches a register that loads on every clock.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

   typedef enum logic [1:0] {
      LM_WIDE    = 2'b00,
      LM_HALF    = 2'b01,
      LM_QUARTER = 2'b10,
      LM_RSVD    = 2'b11
   } lane_mode_e;

   localparam int unsigned FLAG_W = 4;

   // Reserved encoding folds onto the single wide lane.
   function automatic lane_mode_e fold_mode(input logic [1:0] raw);
      lane_mode_e m;
      m = lane_mode_e'(raw);
      if (m == LM_RSVD) m = LM_WIDE;
      return m;
   endfunction

endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
   parameter int unsigned SEG_W = 9
) (
   input  logic [SEG_W-1:0] a,
   input  logic [SEG_W-1:0] b,
   input  logic             cin,
   output logic [SEG_W-1:0] s,
   output logic             cout
);
   localparam int unsigned EXT_W = SEG_W + 1;

   logic [EXT_W-1:0] wide_sum;

   always_comb begin
      wide_sum = {1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, cin};
      s        = wide_sum[SEG_W-1:0];
      cout     = wide_sum[SEG_W];
   end
endmodule

// File: rtl/simd_cut_ctrl.sv
module simd_cut_ctrl
   import simd_add_pkg::*;
#(
   parameter int unsigned NUM_SEG = 4
) (
   input  logic [1:0]         mode,
   output logic [NUM_SEG-1:1] cut
);
   localparam int unsigned SEG_PER_HALF = NUM_SEG / 2;
   localparam int unsigned SEG_PER_QTR  = NUM_SEG / 4;

   lane_mode_e eff_mode;

   always_comb eff_mode = fold_mode(mode);

   for (genvar s = 1; s < NUM_SEG; s++) begin : g_join
      localparam bit HALF_START = (s % SEG_PER_HALF) == 0;
      localparam bit QTR_START  = (s % SEG_PER_QTR) == 0;
      always_comb begin
         unique case (eff_mode)
            LM_HALF:    cut[s] = HALF_START;
            LM_QUARTER: cut[s] = QTR_START;
            default:    cut[s] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/simd_flag_map.sv
module simd_flag_map
   import simd_add_pkg::*;
#(
   parameter int unsigned NUM_SEG = 4
) (
   input  logic [1:0]         mode,
   input  logic [NUM_SEG-1:0] seg_cout,
   output logic [FLAG_W-1:0]  flags
);
   localparam int unsigned SEG_PER_HALF = NUM_SEG / 2;
   localparam int unsigned SEG_PER_QTR  = NUM_SEG / 4;

   lane_mode_e eff_mode;

   always_comb eff_mode = fold_mode(mode);

   for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
      localparam int unsigned QTR_TOP = (k + 1) * SEG_PER_QTR - 1;
      logic half_c;
      logic wide_c;
      if (k < 2) begin : g_half
         assign half_c = seg_cout[(k + 1) * SEG_PER_HALF - 1];
      end else begin : g_no_half
         assign half_c = 1'b0;
      end
      if (k == 0) begin : g_wide
         assign wide_c = seg_cout[NUM_SEG-1];
      end else begin : g_no_wide
         assign wide_c = 1'b0;
      end
      always_comb begin
         unique case (eff_mode)
            LM_HALF:    flags[k] = half_c;
            LM_QUARTER: flags[k] = seg_cout[QTR_TOP];
            default:    flags[k] = wide_c;
         endcase
      end
   end
endmodule

// File: rtl/simd_add_top.sv
module simd_add_top
   import simd_add_pkg::*;
#(
   parameter int unsigned SEG_W   = 9,
   parameter int unsigned NUM_SEG = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [1:0]               mode,
   input  logic [SEG_W*NUM_SEG-1:0] op_a,
   input  logic [SEG_W*NUM_SEG-1:0] op_b,
   output logic                     out_valid,
   output logic [SEG_W*NUM_SEG-1:0] sum,
   output logic [3:0]               lane_carry
);
   localparam int unsigned TOT_W = SEG_W * NUM_SEG;

   if (NUM_SEG < 4 || (NUM_SEG % 4) != 0) begin : g_bad_seg
      $error("simd_add_top: NUM_SEG must be a multiple of 4");
   end
   if (SEG_W < 1) begin : g_bad_w
      $error("simd_add_top: SEG_W must be at least 1");
   end

   logic [NUM_SEG-1:1] cut;
   logic [NUM_SEG-1:0] seg_cin;
   logic [NUM_SEG-1:0] seg_cout;
   logic [TOT_W-1:0]   sum_c;
   logic [FLAG_W-1:0]  flags_c;

   simd_cut_ctrl #(.NUM_SEG(NUM_SEG)) i_cut (
      .mode (mode),
      .cut  (cut)
   );

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      if (s == 0) begin : g_first
         assign seg_cin[s] = 1'b0;
      end else begin : g_chain
         assign seg_cin[s] = seg_cout[s-1] & ~cut[s];
      end
      simd_seg_add #(.SEG_W(SEG_W)) i_seg (
         .a    (op_a[s*SEG_W +: SEG_W]),
         .b    (op_b[s*SEG_W +: SEG_W]),
         .cin  (seg_cin[s]),
         .s    (sum_c[s*SEG_W +: SEG_W]),
         .cout (seg_cout[s])
      );
   end

   simd_flag_map #(.NUM_SEG(NUM_SEG)) i_flags (
      .mode     (mode),
      .seg_cout (seg_cout),
      .flags    (flags_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         sum        <= '0;
         lane_carry <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            sum        <= sum_c;
            lane_carry <= flags_c;
         end
      end
   end
endmodule

// File: rtl/simd_add_chk.sv
module simd_add_chk #(
   parameter int unsigned SEG_W   = 9,
   parameter int unsigned NUM_SEG = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [1:0]               mode,
   input logic [SEG_W*NUM_SEG-1:0] op_a,
   input logic [SEG_W*NUM_SEG-1:0] op_b,
   input logic                     out_valid,
   input logic [SEG_W*NUM_SEG-1:0] sum,
   input logic [3:0]               lane_carry
);
   localparam int unsigned TW = SEG_W * NUM_SEG;
   localparam int unsigned HW = TW / 2;
   localparam int unsigned QW = TW / 4;

   a_r6_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r6_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(sum) && $stable(lane_carry)));

   a_r1_wide_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b00) |=>
      ({lane_carry[0], sum} == $past({1'b0, op_a} + {1'b0, op_b})));

   a_r4_rsvd_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b11) |=>
      ({lane_carry[0], sum} == $past({1'b0, op_a} + {1'b0, op_b})));

   a_r2_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b01) |=>
      ({lane_carry[1], sum[TW-1:HW]} ==
       $past({1'b0, op_a[TW-1:HW]} + {1'b0, op_b[TW-1:HW]})));

   a_r3_low_quarter: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b10) |=>
      ({lane_carry[0], sum[QW-1:0]} ==
       $past({1'b0, op_a[QW-1:0]} + {1'b0, op_b[QW-1:0]})));

   a_r3_top_quarter: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b10) |=>
      ({lane_carry[3], sum[TW-1:TW-QW]} ==
       $past({1'b0, op_a[TW-1:TW-QW]} + {1'b0, op_b[TW-1:TW-QW]})));

   a_r5_wide_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode[0] == mode[1]) |=> (lane_carry[3:1] == 3'b000));

   a_r5_half_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b01) |=> (lane_carry[3:2] == 2'b00));
endmodule

bind simd_add_top simd_add_chk #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) i_simd_add_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .mode       (mode),
   .op_a       (op_a),
   .op_b       (op_b),
   .out_valid  (out_valid),
   .sum        (sum),
   .lane_carry (lane_carry)
);

// File: tb/test_simd_add_top.sv
module test_simd_add_top;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned W = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic [W-1:0]  op_a = '0;
   logic [W-1:0]  op_b = '0;
   logic          out_valid;
   logic [W-1:0]  sum;
   logic [3:0]    lane_carry;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_add_top i_simd_add_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .mode       (mode),
      .op_a       (op_a),
      .op_b       (op_b),
      .out_valid  (out_valid),
      .sum        (sum),
      .lane_carry (lane_carry)
   );

   // Reference: add each lane slice on its own, 64-bit arithmetic.
   function automatic logic [W+3:0] ref_add(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic [1:0]   m);
      int unsigned       lanes;
      int unsigned       lw;
      longint unsigned   mask;
      longint unsigned   part;
      logic [W-1:0]      res;
      logic [3:0]        cf;
      lanes = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
      lw    = W / lanes;
      mask  = (64'd1 << lw) - 64'd1;
      res   = '0;
      cf    = '0;
      for (int l = 0; l < lanes; l++) begin
         part = ((64'(a) >> (l*lw)) & mask) + ((64'(b) >> (l*lw)) & mask);
         res  = res | W'((part & mask) << (l*lw));
         cf[l] = part[lw];
      end
      return {cf, res};
   endfunction

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one operation; results checked at the following negedge.
   task automatic apply(input string req, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [1:0] m);
      logic [W+3:0] e;
      e = ref_add(a, b, m);
      @(negedge clk);
      op_a = a; op_b = b; mode = m; in_valid = 1'b1;
      @(negedge clk);
      check({req, " sum"},   64'(sum),        64'(e[W-1:0]));
      check({req, " carry"}, 64'(lane_carry), 64'(e[W+3:W]));
      check("R6 valid high", 64'(out_valid), 64'd1);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R8 valid", 64'(out_valid), 64'd0);
      check("R8 sum",   64'(sum),       64'd0);
      check("R8 carry", 64'(lane_carry), 64'd0);
   endtask

   task automatic t_random(input logic [1:0] m, input string req);
      for (int i = 0; i < 40; i++)
         apply(req, {$urandom, $urandom} & 36'hF_FFFF_FFFF,
                    {$urandom, $urandom} & 36'hF_FFFF_FFFF, m);
   endtask

   task automatic t_ones;
      for (int m = 0; m < 4; m++) begin
         apply("R1 R2 R3 R4 all-ones", '1, '1, 2'(m));
         apply("R1 R2 R3 R4 ones+one", '1, 36'd1, 2'(m));
         apply("R2 R3 R5 slice boundary", '1, {4{9'd1}}, 2'(m));
      end
   endtask

   task automatic t_boundary;
      // carry generated exactly at each segment top
      apply("R3 cut at 9",  36'h0_0000_01FF, 36'd1, 2'b10);
      apply("R2 cut at 18", 36'h0_0003_FFFF, 36'd1, 2'b01);
      apply("R1 ripple 18", 36'h0_0003_FFFF, 36'd1, 2'b00);
      apply("R3 cut at 27", 36'h0_07FC_0000, 36'h0_0004_0000, 2'b10);
      apply("R4 rsvd ripple", 36'h0_0003_FFFF, 36'd1, 2'b11);
      apply("R5 half unused", '1, '1, 2'b01);
   endtask

   task automatic t_hold;
      logic [W-1:0] s0;
      logic [3:0]   c0;
      apply("R7 setup", 36'h1_2345_6789, 36'h8_7654_3210, 2'b10);
      s0 = sum; c0 = lane_carry;
      @(negedge clk);
      op_a = '1; op_b = '1; mode = 2'b00; in_valid = 1'b0;
      check("R6 valid low", 64'(out_valid), 64'd0);
      repeat (3) @(negedge clk);
      check("R7 sum held",   64'(sum),        64'(s0));
      check("R7 carry held", 64'(lane_carry), 64'(c0));
      check("R6 valid low",  64'(out_valid),  64'd0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_random(2'b00, "R1 random");
      t_random(2'b01, "R2 random");
      t_random(2'b10, "R3 random");
      t_random(2'b11, "R4 random");
      t_ones;
      t_boundary;
      t_hold;
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
   end
endmodule